// File: doc/BRIEF.md
# Configuration Image Preamble Scanner

This block sits in the path of a configuration image delivered one byte per handshake. It finds the point where raw configuration data begins, throws away every byte before it, and passes every byte from that point to the end of the image through a valid/ready byte output. It also reports the byte offset of that point, or a not-found flag when the image contains no valid start. The image length is given on an input. A reset starts a new image.

Two start rules are supported, and the `mode` input selects one of them. Mode 0 is uncompressed. The scanner first steps over a header of four length-prefixed text fields. The first length byte is at offset 15. Each field moves the walk forward by its length plus three. After the header, the scanner looks for four 0xFF bytes in a row, and forwarding starts with the first of them. Mode 1 is compressed. The header is ignored and the search starts at offset 0. It looks for 0xFF followed by a byte whose high nibble is 3. Data starts two bytes after the 0xFF, so that pair is not forwarded.

Top module: `cfg_preamble_scan`

## Requirements
- R1: After reset, `out_valid`, `found`, `not_found` and `done` are 0 and `data_start` is 0. `in_ready` is 1 when `img_len` is non-zero.
- R2: In mode 0, the byte at offset 15 is a length L. The next length byte is at the current offset plus L+3. Exactly four lengths are read this way. 0xFF bytes at or before the end of the fourth field never count toward the preamble.
- R3: In mode 0, the first run of four consecutive 0xFF bytes that begins at or after the header end sets `found`. `data_start` takes the offset of the first 0xFF of that run. The output stream begins with those four 0xFF bytes.
- R4: In mode 0, a run of one to three 0xFF bytes that is broken by another value is not forwarded.
- R5: In mode 1, the first 0xFF at offset i that is followed by a byte with bits [7:4] equal to 4'h3 sets `found`, and `data_start` is i+2. Neither byte of the pair is forwarded. No header is walked.
- R6: In mode 1, a 0xFF in the last byte of the image is not a match.
- R7: When all `img_len` bytes have been consumed without a match, or `img_len` is 0, `not_found` rises. `done` is also high, and no byte is ever output. `found` and `not_found` are never both high.
- R8: After the start, the bytes from `data_start` through `img_len`-1 are output in order, each exactly once. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values.
- R9: Once all `img_len` bytes have been consumed and any held preamble bytes flushed, `done` is high. `in_ready` and `out_valid` then stay low until reset.
- R10: Once `found` is set, it stays high and `data_start` does not change until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; starts a new image |
| mode | input | 1 | 0 = uncompressed rule, 1 = compressed rule; held stable during an image |
| img_len | input | LW | Image length in bytes |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Downstream accepts output byte |
| found | output | 1 | Data start located |
| not_found | output | 1 | Image ended with no data start |
| done | output | 1 | Image fully consumed and flushed |
| data_start | output | LW | Byte offset where data begins |

## Verification
The hardest situation to reach is a mode 0 image in which 0xFF bytes can be mistaken for the preamble. This covers header text made of 0xFF, a header that ends directly into the real run, and a broken partial run just before it. The last case must leave no stray bytes on the output. The stimulus builds each image from a short table row. It fills all header text and the leading 15 bytes with 0xFF, inserts a partial run of chosen length, and throttles `out_ready`. The throttling makes the four held 0xFF bytes drain under backpressure. Compressed images add a decoy 0xFF that is followed by a non-matching byte, as well as a trailing lone 0xFF.

// File: rtl/cfg_preamble_scan.sv
module cfg_preamble_scan #(
  parameter int LW      = 24,
  parameter int HDR_OFS = 15,
  parameter int NFIELD  = 4,
  parameter int RUN     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode,
  input  logic [LW-1:0] img_len,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic [7:0]    out_data,
  input  logic          out_ready,
  output logic          found,
  output logic          not_found,
  output logic          done,
  output logic [LW-1:0] data_start
);
  localparam int FW = $clog2(NFIELD + 1);
  localparam int RW = $clog2(RUN);
  localparam int PW = $clog2(RUN + 1);

  typedef enum logic [1:0] {SCAN, FLUSH, PASS, FIN} st_t;

  st_t           st;
  logic [LW-1:0] pos, nxt;
  logic [FW-1:0] fcnt;
  logic [RW-1:0] run;
  logic [PW-1:0] pend;
  logic          cand;

  wire avail    = pos < img_len;
  wire take     = in_valid && in_ready;
  wire is_ff    = in_data == 8'hFF;
  wire hdr_done = fcnt == FW'(NFIELD);
  wire srch_u   = !mode && hdr_done && pos >= nxt;
  wire hit_u    = take && st == SCAN && srch_u && is_ff && run == RW'(RUN - 1);
  wire hit_c    = take && st == SCAN && mode && cand && in_data[7:4] == 4'h3;

  assign in_ready  = (st == SCAN && avail) || (st == PASS && avail && out_ready);
  assign out_valid = (st == FLUSH) || (st == PASS && avail && in_valid);
  assign out_data  = (st == FLUSH) ? 8'hFF : in_data;
  assign done      = st == FIN;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= SCAN;
      pos        <= '0;
      nxt        <= LW'(HDR_OFS);
      fcnt       <= '0;
      run        <= '0;
      pend       <= '0;
      cand       <= 1'b0;
      found      <= 1'b0;
      not_found  <= 1'b0;
      data_start <= '0;
    end else begin
      if (take) pos <= pos + LW'(1);
      case (st)
        SCAN: begin
          if (!avail) begin
            st        <= FIN;
            not_found <= 1'b1;
          end else if (take) begin
            if (!mode && !hdr_done && pos == nxt) begin
              nxt  <= nxt + LW'(in_data) + LW'(3);
              fcnt <= fcnt + FW'(1);
            end
            if (hit_u) begin
              found      <= 1'b1;
              data_start <= pos - LW'(RUN - 1);
              pend       <= PW'(RUN);
              run        <= '0;
              st         <= FLUSH;
            end else if (srch_u) begin
              run <= is_ff ? run + RW'(1) : '0;
            end
            if (hit_c) begin
              found      <= 1'b1;
              data_start <= pos + LW'(1);
              cand       <= 1'b0;
              st         <= PASS;
            end else begin
              cand <= mode && is_ff;
            end
          end
        end
        FLUSH: begin
          if (out_ready) begin
            pend <= pend - PW'(1);
            if (pend == PW'(1)) st <= PASS;
          end
        end
        PASS: begin
          if (!avail) st <= FIN;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cfg_preamble_scan_chk.sv
module cfg_preamble_scan_chk #(
  parameter int LW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          out_valid,
  input logic [7:0]    out_data,
  input logic          out_ready,
  input logic          found,
  input logic          not_found,
  input logic          done,
  input logic [LW-1:0] data_start
);
  // R7
  excl_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(found && not_found));

  // R7
  nf_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    not_found |-> done);

  // R3
  out_after_found_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> found);

  // R8
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R9
  idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!in_ready && !out_valid));

  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  // R10
  found_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    found |=> (found && $stable(data_start)));
endmodule

bind cfg_preamble_scan cfg_preamble_scan_chk #(.LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_data(out_data), .out_ready(out_ready), .found(found),
  .not_found(not_found), .done(done), .data_start(data_start)
);

// File: tb/sim_cfg_preamble_scan.sv
module sim_cfg_preamble_scan;
  localparam int LW = 24;

  logic          clk = 0, rst_n = 0, mode = 0;
  logic [LW-1:0] img_len = '0;
  logic          in_valid = 0, out_ready = 1;
  logic [7:0]    in_data = '0;
  logic          in_ready, out_valid, found, not_found, done;
  logic [7:0]    out_data;
  logic [LW-1:0] data_start;

  cfg_preamble_scan #(.LW(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .img_len(img_len),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .found(found), .not_found(not_found), .done(done), .data_start(data_start)
  );

  always #10 clk = ~clk;

  typedef struct packed {
    logic       md;
    logic [7:0] a, b, c, d;
    logic [2:0] part;
    logic       pre;
    logic       endff;
    logic [7:0] tail;
    logic       stall;
    logic       exf;
  } vec_t;

  localparam vec_t VT [0:7] = '{
    '{1'b0, 8'd2, 8'd0, 8'd5, 8'd1, 3'd0, 1'b1, 1'b0, 8'd10, 1'b0, 1'b1},
    '{1'b0, 8'd0, 8'd3, 8'd0, 8'd7, 3'd3, 1'b1, 1'b0, 8'd20, 1'b1, 1'b1},
    '{1'b0, 8'd4, 8'd4, 8'd4, 8'd4, 3'd2, 1'b0, 1'b0, 8'd6,  1'b0, 1'b0},
    '{1'b0, 8'd1, 8'd1, 8'd1, 8'd1, 3'd1, 1'b1, 1'b0, 8'd0,  1'b1, 1'b1},
    '{1'b1, 8'd3, 8'd0, 8'd0, 8'd0, 3'd0, 1'b1, 1'b0, 8'd12, 1'b0, 1'b1},
    '{1'b1, 8'd0, 8'd0, 8'd0, 8'd0, 3'd1, 1'b1, 1'b0, 8'd9,  1'b1, 1'b1},
    '{1'b1, 8'd5, 8'd0, 8'd0, 8'd0, 3'd1, 1'b0, 1'b1, 8'd3,  1'b0, 1'b0},
    '{1'b1, 8'd2, 8'd0, 8'd0, 8'd0, 3'd0, 1'b1, 1'b0, 8'd0,  1'b0, 1'b1}
  };

  int total = 0, bad = 0, cyc = 0;
  logic [7:0] img [0:2047];
  logic [7:0] got [0:2047];
  int n = 0, gn = 0, stall_bad = 0;
  bit stall_en = 0;
  bit prev_stall = 0;
  logic [7:0] prev_data = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(negedge clk) out_ready = !stall_en || (cyc % 3 != 0);

  always begin
    @(negedge clk); #1;
    if (rst_n) begin
      if (prev_stall && !(out_valid && out_data == prev_data)) stall_bad++;
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      if (out_valid && out_ready) begin got[gn] = out_data; gn++; end
    end else prev_stall = 0;
  end

  task automatic put(input logic [7:0] b);
    img[n] = b; n++;
  endtask

  task automatic build(input vec_t v);
    n = 0;
    if (!v.md) begin
      logic [7:0] ls [4];
      ls[0] = v.a; ls[1] = v.b; ls[2] = v.c; ls[3] = v.d;
      for (int k = 0; k < 15; k++) put(8'hFF);
      for (int f = 0; f < 4; f++) begin
        put(ls[f]);
        for (int k = 0; k < int'(ls[f]) + 2; k++) put(8'hFF);
      end
      if (v.part != 0) begin
        for (int k = 0; k < int'(v.part); k++) put(8'hFF);
        put(8'h00);
      end
      if (v.pre) for (int k = 0; k < 4; k++) put(8'hFF);
      for (int k = 0; k < int'(v.tail); k++) put(8'((k * 37 + 5) & 8'h7F));
    end else begin
      for (int k = 0; k < int'(v.a); k++) put(8'(8'h10 + k % 16));
      if (v.part != 0) begin put(8'hFF); put(8'h20); end
      if (v.pre) begin put(8'hFF); put(8'h3A); end
      for (int k = 0; k < int'(v.tail); k++) put(8'(8'h40 + k % 32));
      if (v.endff) put(8'hFF);
    end
  endtask

  function automatic int ref_ds(input bit md);
    if (!md) begin
      int o = 15;
      for (int f = 0; f < 4; f++) o += int'(img[o]) + 3;
      for (int i = o; i + 3 < n; i++)
        if (img[i] == 8'hFF && img[i+1] == 8'hFF && img[i+2] == 8'hFF && img[i+3] == 8'hFF)
          return i;
    end else begin
      for (int i = 0; i + 1 < n; i++)
        if (img[i] == 8'hFF && img[i+1][7:4] == 4'h3) return i + 2;
    end
    return -1;
  endfunction

  task automatic do_reset(input bit md, input int len);
    @(negedge clk);
    rst_n = 0; in_valid = 0; mode = md; img_len = LW'(len);
    repeat (2) @(negedge clk);
    gn = 0; stall_bad = 0;
    rst_n = 1;
  endtask

  task automatic feed();
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (k % 5 == 3) begin in_valid = 0; @(negedge clk); end
      in_valid = 1; in_data = img[k];
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
    end
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 40 && !done; k++) @(negedge clk);
    #2;
  endtask

  initial begin
    // R1: reset state
    stall_en = 0;
    do_reset(1'b0, 10);
    #2;
    chk(!out_valid && !found && !not_found && !done, "R1", "flags", {found, not_found, done}, 0);
    chk(data_start == 0, "R1", "data_start", int'(data_start), 0);
    chk(in_ready == 1, "R1", "in_ready", int'(in_ready), 1);

    foreach (VT[i]) begin
      vec_t v = VT[i];
      int eds, mism;
      string tg;
      build(v);
      eds = ref_ds(v.md);
      tg = v.md ? (v.endff ? "R6" : "R5") : (v.part != 0 ? "R4" : "R3");
      stall_en = v.stall;
      do_reset(v.md, n);
      feed();
      wait_done();
      chk(found == v.exf, tg, "found", int'(found), int'(v.exf));
      chk(not_found == !v.exf, "R7", "not_found", int'(not_found), int'(!v.exf));
      if (v.exf) begin
        chk(int'(data_start) == eds, v.md ? "R5" : "R2", "data_start", int'(data_start), eds);
        chk(gn == n - eds, "R8", "byte count", gn, n - eds);
        mism = 0;
        for (int k = 0; k < gn && eds + k < n; k++) if (got[k] != img[eds + k]) mism++;
        chk(mism == 0, tg, "byte mismatches", mism, 0);
      end else begin
        chk(gn == 0, "R7", "bytes out", gn, 0);
      end
      if (v.stall) chk(stall_bad == 0, "R8", "stall hold", stall_bad, 0);
      chk(done == 1, "R9", "done", int'(done), 1);
    end

    // R7: zero length image
    stall_en = 0;
    do_reset(1'b0, 0);
    @(negedge clk); @(negedge clk); #2;
    chk(not_found && done && !found, "R7", "zero length", {found, not_found, done}, 3);

    // R9: inputs ignored once done
    in_valid = 1; in_data = 8'hFF;
    repeat (3) @(negedge clk);
    #2;
    chk(!in_ready && !out_valid, "R9", "idle after done", {in_ready, out_valid}, 0);
    chk(done && data_start == 0, "R10", "state kept", int'(data_start), 0);
    in_valid = 0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule